// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one inter-processor interrupt command into the set of local interrupt controllers that must receive it. A command carries a destination byte, a physical/logical addressing flag, a two-bit shorthand, a three-bit delivery mode and the level and trigger bits. The block holds no configuration of its own. Each of the `SLOTS` controller slots reports four things on the configuration inputs: whether the slot is populated, its physical ID, its logical ID and its logical format model.

One clock after a command is accepted, the block presents a registered target mask with a one-cycle valid strobe. There is one exception. An INIT command with level 0 and trigger 1 resynchronises arbitration IDs rather than delivering anything, so for that command the selected slots appear on a separate per-slot reload strobe and the valid strobe stays low. Lowest-priority commands are narrowed to one target by a fixed rule: the lowest-indexed candidate wins. The block does no priority arbitration.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `tgtValid`, `tgtMask` and `arbReload` are all zero.
- R2: For a physical command (`reqLogical`=0, shorthand 0) with destination 8'hFF, the mask holds every populated slot.
- R3: For a physical command with any other destination, the mask holds only the lowest-indexed populated slot whose physical ID equals the destination. The mask is zero if no populated slot has that ID.
- R4: For a logical command (`reqLogical`=1, shorthand 0), a slot with format 4'hF is selected when the destination ANDed with its logical ID is nonzero.
- R5: For a logical command, a slot with format 4'h0 is selected when the upper nibbles of the destination and its logical ID are equal and their lower nibbles share a set bit. A slot with any other format value is never selected in logical mode.
- R6: Shorthand overrides the destination fields. 1 selects only slot `senderIdx`, 2 selects all slots, and 3 selects all slots except `senderIdx`.
- R7: With delivery mode 3'd1 (lowest priority), only the lowest-indexed selected slot stays in the mask.
- R8: A command with delivery mode 3'd5, level 0 and trigger 1 leaves `tgtValid` low and `tgtMask` zero, and pulses `arbReload` with the selected slots for one cycle. Every other command, including mode 5 with level 1, produces a normal mask.
- R9: Outputs are registered and appear exactly one cycle after `reqValid`. In cycles without a command on the previous edge, all three outputs are zero.
- R10: A slot whose `slotPresent` bit is 0 never appears in `tgtMask` or `arbReload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command present this cycle |
| reqDest | input | 8 | Destination byte |
| reqLogical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| reqShorthand | input | 2 | 0 addressed, 1 self, 2 all, 3 all but self |
| reqMode | input | 3 | Delivery mode (1 lowest priority, 5 INIT) |
| reqLevel | input | 1 | Level bit of the command |
| reqTrigger | input | 1 | Trigger bit of the command |
| senderIdx | input | IDX_W | Slot index of the sending controller |
| slotPresent | input | SLOTS | Per-slot populated flag |
| slotPhysId | input | SLOTS*8 | Physical IDs, slot i in bits [8i+7:8i] |
| slotLogId | input | SLOTS*8 | Logical IDs, slot i in bits [8i+7:8i] |
| slotFormat | input | SLOTS*4 | Logical format model, slot i in bits [4i+3:4i] |
| tgtValid | output | 1 | Mask valid strobe |
| tgtMask | output | SLOTS | Selected delivery targets |
| arbReload | output | SLOTS | Per-slot arbitration-ID reload strobe |

## Verification
The in-RTL properties compare registered outputs with `$past` of the decoded command and of `slotPresent`. They assume that the slot configuration and `senderIdx` are stable while the command travels through the output register. The bench honours this by changing the configuration only between commands, with at least one idle edge in between. The properties also assume `senderIdx` names a real slot, and the stimulus only ever drives indices below `SLOTS`. The sweeps cover every destination byte under both logical models, including a slot with an invalid format. They also cover duplicate physical IDs, an unpopulated slot as sender, and all 256 population patterns.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  // Shorthand route codes; the numeric order is the command encoding.
  typedef enum logic [1:0] {
    ROUTE_ADDR   = 2'd0,
    ROUTE_SELF   = 2'd1,
    ROUTE_ALL    = 2'd2,
    ROUTE_OTHERS = 2'd3
  } route_e;

  localparam logic [2:0] MODE_LOWEST = 3'd1;
  localparam logic [2:0] MODE_INIT   = 3'd5;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  // Decoded command handed from control to datapath.
  typedef struct packed {
    logic       load;       // a command is accepted this cycle
    logic       arbLoad;    // command is an arbitration-ID resync
    logic       pickFirst;  // reduce the selection to its lowest index
    logic       logical;    // logical addressing
    route_e     routeSel;   // shorthand route
    logic [7:0] dest;       // destination byte
  } ctrl_strobes_t;

endpackage

// File: rtl/irq_dest_ctrl.sv
module irq_dest_ctrl
  import irq_dest_pkg::*;
(
  input  logic          reqValid,
  input  logic [7:0]    reqDest,
  input  logic          reqLogical,
  input  logic [1:0]    reqShorthand,
  input  logic [2:0]    reqMode,
  input  logic          reqLevel,
  input  logic          reqTrigger,
  output ctrl_strobes_t strobes
);

  logic   initDeassert;
  logic   singlePhys;
  route_e route;

  always_comb begin
    route        = route_e'(reqShorthand);
    initDeassert = (reqMode == MODE_INIT) && !reqLevel && reqTrigger;
    // A unicast physical address resolves to one slot even with duplicate IDs.
    singlePhys   = (route == ROUTE_ADDR) && !reqLogical && (reqDest != DEST_BCAST);

    strobes.load      = reqValid;
    strobes.arbLoad   = reqValid && initDeassert;
    strobes.pickFirst = (reqMode == MODE_LOWEST) || singlePhys;
    strobes.logical   = reqLogical;
    strobes.routeSel  = route;
    strobes.dest      = reqDest;
  end

endmodule

// File: rtl/irq_dest_datapath.sv
module irq_dest_datapath
  import irq_dest_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strobes,
  input  logic [IDX_W-1:0]   senderIdx,
  input  logic [SLOTS-1:0]   slotPresent,
  input  logic [SLOTS*8-1:0] slotPhysId,
  input  logic [SLOTS*8-1:0] slotLogId,
  input  logic [SLOTS*4-1:0] slotFormat,
  output logic               tgtValid,
  output logic [SLOTS-1:0]   tgtMask,
  output logic [SLOTS-1:0]   arbReload
);

  logic [SLOTS-1:0] routeHit;
  logic [SLOTS-1:0] rawHit;
  logic [SLOTS-1:0] firstHit;
  logic [SLOTS-1:0] finalHit;

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [7:0] physId;
    logic [7:0] logId;
    logic [3:0] fmt;
    logic       flatHit;
    logic       clusterHit;
    logic       addrHit;
    logic       isSender;

    always_comb begin
      physId     = slotPhysId[g*8 +: 8];
      logId      = slotLogId[g*8 +: 8];
      fmt        = slotFormat[g*4 +: 4];
      flatHit    = (fmt == FMT_FLAT) && ((strobes.dest & logId) != 8'h00);
      clusterHit = (fmt == FMT_CLUSTER) &&
                   (strobes.dest[7:4] == logId[7:4]) &&
                   ((strobes.dest[3:0] & logId[3:0]) != 4'h0);
      if (strobes.logical) begin
        addrHit = flatHit || clusterHit;
      end else begin
        addrHit = (strobes.dest == DEST_BCAST) || (strobes.dest == physId);
      end
      isSender = (senderIdx == IDX_W'(g));
      unique case (strobes.routeSel)
        ROUTE_ADDR:   routeHit[g] = addrHit;
        ROUTE_SELF:   routeHit[g] = isSender;
        ROUTE_ALL:    routeHit[g] = 1'b1;
        ROUTE_OTHERS: routeHit[g] = !isSender;
        default:      routeHit[g] = 1'b0;
      endcase
    end
  end

  always_comb begin
    rawHit   = routeHit & slotPresent;
    firstHit = rawHit & (~rawHit + 1'b1);
    finalHit = strobes.pickFirst ? firstHit : rawHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtValid  <= 1'b0;
      tgtMask   <= '0;
      arbReload <= '0;
    end else begin
      tgtValid  <= strobes.load && !strobes.arbLoad;
      tgtMask   <= (strobes.load && !strobes.arbLoad) ? finalHit : '0;
      arbReload <= strobes.arbLoad ? finalHit : '0;
    end
  end

  // R9: a mask strobe only follows an accepted command
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid |-> $past(strobes.load));

  // R9: an idle cycle leaves the mask clear
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.load) |-> (tgtMask == '0 && arbReload == '0));

  // R8: reload strobe and mask strobe never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (arbReload != '0) |-> (!tgtValid && $past(strobes.arbLoad)));

  // R10: unpopulated slots never selected
  a_r10_present: assert property (@(posedge clk) disable iff (!rstN)
    ((tgtMask | arbReload) & ~$past(slotPresent)) == '0);

  // R7 and R3: a narrowed selection holds at most one slot
  a_r7_single: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && $past(strobes.pickFirst)) |-> $onehot0(tgtMask));

  // R6: self shorthand names at most the sender
  a_r6_self: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && $past(strobes.routeSel == ROUTE_SELF)) |-> $countones(tgtMask) <= 1);

  // R2 and R6: a full broadcast equals the population
  a_r6_all: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid && $past(strobes.routeSel == ROUTE_ALL && !strobes.pickFirst))
      |-> (tgtMask == $past(slotPresent)));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [7:0]         reqDest,
  input  logic               reqLogical,
  input  logic [1:0]         reqShorthand,
  input  logic [2:0]         reqMode,
  input  logic               reqLevel,
  input  logic               reqTrigger,
  input  logic [IDX_W-1:0]   senderIdx,
  input  logic [SLOTS-1:0]   slotPresent,
  input  logic [SLOTS*8-1:0] slotPhysId,
  input  logic [SLOTS*8-1:0] slotLogId,
  input  logic [SLOTS*4-1:0] slotFormat,
  output logic               tgtValid,
  output logic [SLOTS-1:0]   tgtMask,
  output logic [SLOTS-1:0]   arbReload
);

  ctrl_strobes_t strobes;

  irq_dest_ctrl i_ctrl (
    .reqValid     (reqValid),
    .reqDest      (reqDest),
    .reqLogical   (reqLogical),
    .reqShorthand (reqShorthand),
    .reqMode      (reqMode),
    .reqLevel     (reqLevel),
    .reqTrigger   (reqTrigger),
    .strobes      (strobes)
  );

  irq_dest_datapath #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .senderIdx   (senderIdx),
    .slotPresent (slotPresent),
    .slotPhysId  (slotPhysId),
    .slotLogId   (slotLogId),
    .slotFormat  (slotFormat),
    .tgtValid    (tgtValid),
    .tgtMask     (tgtMask),
    .arbReload   (arbReload)
  );

endmodule

// File: tb/test_irq_dest_resolver.sv
module test_irq_dest_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [7:0]   reqDest = '0;
  logic         reqLogical = 1'b0;
  logic [1:0]   reqShorthand = '0;
  logic [2:0]   reqMode = '0;
  logic         reqLevel = 1'b0;
  logic         reqTrigger = 1'b0;
  logic [2:0]   senderIdx = '0;
  logic [N-1:0] slotPresent = '0;
  logic [N*8-1:0] slotPhysId;
  logic [N*8-1:0] slotLogId;
  logic [N*4-1:0] slotFormat;
  logic         tgtValid;
  logic [N-1:0] tgtMask;
  logic [N-1:0] arbReload;

  logic [7:0] cfgPhys [N];
  logic [7:0] cfgLog  [N];
  logic [3:0] cfgFmt  [N];

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      slotPhysId[i*8 +: 8] = cfgPhys[i];
      slotLogId[i*8 +: 8]  = cfgLog[i];
      slotFormat[i*4 +: 4] = cfgFmt[i];
    end
  end

  irq_dest_resolver #(.SLOTS(N)) i_irq_dest_resolver (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDest(reqDest),
    .reqLogical(reqLogical), .reqShorthand(reqShorthand), .reqMode(reqMode),
    .reqLevel(reqLevel), .reqTrigger(reqTrigger), .senderIdx(senderIdx),
    .slotPresent(slotPresent), .slotPhysId(slotPhysId), .slotLogId(slotLogId),
    .slotFormat(slotFormat), .tgtValid(tgtValid), .tgtMask(tgtMask),
    .arbReload(arbReload)
  );

  // Expected {valid, mask, reload} from the requirements.
  function automatic logic [2*N:0] model(logic [7:0] d, logic lg, logic [1:0] sh,
                                         logic [2:0] md, logic lv, logic tr,
                                         logic [2:0] snd);
    logic [N-1:0] sel = '0;
    logic [N-1:0] pick = '0;
    logic reload;
    for (int i = 0; i < N; i++) begin
      logic hit;
      case (sh)
        2'd0: begin
          if (lg) begin
            if (cfgFmt[i] == 4'hF) hit = (d & cfgLog[i]) != 0;
            else if (cfgFmt[i] == 4'h0)
              hit = (d[7:4] == cfgLog[i][7:4]) && ((d[3:0] & cfgLog[i][3:0]) != 0);
            else hit = 1'b0;
          end else begin
            hit = (d == 8'hFF) || (d == cfgPhys[i]);
          end
        end
        2'd1:    hit = (i == int'(snd));
        2'd2:    hit = 1'b1;
        default: hit = (i != int'(snd));
      endcase
      sel[i] = hit && slotPresent[i];
    end
    if (md == 3'd1 || (sh == 2'd0 && !lg && d != 8'hFF)) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (sel[i]) pick = N'(1) << i;
      end
    end else begin
      pick = sel;
    end
    reload = (md == 3'd5) && !lv && tr;
    return reload ? {1'b0, {N{1'b0}}, pick} : {1'b1, pick, {N{1'b0}}};
  endfunction

  task automatic compare(logic [2*N:0] exp, string tag);
    logic [2*N:0] act = {tgtValid, tgtMask, arbReload};
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual valid/mask/reload=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] md,
                       logic lv, logic tr, logic [2:0] snd, string tag);
    @(negedge clk);
    reqDest = d; reqLogical = lg; reqShorthand = sh; reqMode = md;
    reqLevel = lv; reqTrigger = tr; senderIdx = snd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    compare(model(d, lg, sh, md, lv, tr, snd), tag);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    compare('0, "R9");
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000 / CLK_PERIOD) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // Config A: distinct physical IDs except slot 5 duplicates slot 2; all flat.
    for (int i = 0; i < N; i++) begin
      cfgPhys[i] = 8'h10 + 8'(i);
      cfgLog[i]  = 8'(1) << i;
      cfgFmt[i]  = 4'hF;
    end
    cfgPhys[5] = 8'h12;
    slotPresent = 8'b1011_1111;  // slot 6 unpopulated

    // R1: reset state, during reset and just after release
    repeat (3) @(negedge clk);
    compare('0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    compare('0, "R1");

    // R2 / R3: physical destinations, every byte
    for (int d = 0; d < 256; d++) begin
      issue(8'(d), 1'b0, 2'd0, 3'd0, 1'b1, 1'b0, 3'd0, (d == 255) ? "R2" : "R3");
    end
    idleCheck();

    // R4: flat logical model, every byte
    for (int d = 0; d < 256; d++) issue(8'(d), 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 3'd0, "R4");

    // R7: lowest priority over flat logical and physical broadcast
    for (int d = 0; d < 256; d++) issue(8'(d), 1'b1, 2'd0, 3'd1, 1'b1, 1'b0, 3'd0, "R7");
    issue(8'hFF, 1'b0, 2'd0, 3'd1, 1'b1, 1'b0, 3'd0, "R7");
    idleCheck();

    // R5: cluster model in two clusters; slot 7 has an invalid format
    for (int i = 0; i < N; i++) begin
      cfgLog[i] = {4'(i / 4 + 2), 4'(1 << (i % 4))};
      cfgFmt[i] = 4'h0;
    end
    cfgFmt[7] = 4'h5;
    slotPresent = 8'hFF;
    idleCheck();
    for (int d = 0; d < 256; d++) issue(8'(d), 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 3'd0, "R5");
    idleCheck();

    // R6: shorthand over every sender, with slot 6 unpopulated
    slotPresent = 8'b1011_1111;
    idleCheck();
    for (int sh = 1; sh < 4; sh++) begin
      for (int s = 0; s < N; s++) begin
        issue(8'h12, 1'b0, 2'(sh), 3'd0, 1'b1, 1'b0, 3'(s), "R6");
        issue(8'h23, 1'b1, 2'(sh), 3'd1, 1'b1, 1'b0, 3'(s), "R6");
      end
    end

    // R8: INIT resync vs. INIT assert vs. other level/trigger combinations
    for (int sh = 0; sh < 4; sh++) begin
      for (int lt = 0; lt < 4; lt++) begin
        issue(8'hFF, 1'b0, 2'(sh), 3'd5, lt[0], lt[1], 3'd2, "R8");
        idleCheck();
      end
    end
    for (int d = 0; d < 256; d += 5) issue(8'(d), 1'b1, 2'd0, 3'd5, 1'b0, 1'b1, 3'd0, "R8");

    // R10: every population pattern under broadcast and resync
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      slotPresent = 8'(p);
      issue(8'h00, 1'b0, 2'd2, 3'd0, 1'b1, 1'b0, 3'd0, "R10");
      issue(8'hFF, 1'b0, 2'd0, 3'd5, 1'b0, 1'b1, 3'd0, "R10");
    end
    idleCheck();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule